// File: doc/BRIEF.md
# Level-Tracking Interrupt Hub with Shared Multi-Source Vector

This block collects thirty level-sensitive interrupt sources and two non-maskable sources and presents them to a processor core. The core sees three things: a maskable request wire, an 8-bit vector bus and a separate non-maskable request wire. A single enabled source produces a vector that names it. Any mix of two or more enabled sources produces one shared vector. The interrupt routine then reads the status words and applies its own priority order. The block does not rank the sources.

Software reaches five 32-bit words through a small word-addressed port. These are the enable mask, the raw line image, the gated (masked) image, the non-maskable status and a fatal-exception status word. Each source line updates its raw bit only when its level changes. A value that software writes into the raw image therefore holds until the line next moves. Sub-word accesses read as zero and are dropped on write. Offsets outside the map raise a one-cycle error.

Top module: `irq_hub`

## Requirements
- R1: Word accesses (size 2) read and write the enable mask at offset 0x00, the raw image at 0x04, the non-maskable status at 0x0C and the fatal-exception word at 0x10. Read data and the error flag appear on the cycle after the request.
- R2: Source line n (irq_lines bit n-1, n = 1..30) drives bit n-1 of the raw image to its level. The new value shows on the cycle after the edge that samples a level change.
- R3: A read of offset 0x08 always returns the raw image ANDed with the enable mask. Writes to 0x08 change nothing.
- R4: When exactly one gated bit i is set, cpu_vector is 0x31 + i and cpu_irq is high.
- R5: When two or more gated bits are set, cpu_vector is 0x30 and cpu_irq is high.
- R6: When no gated bit is set, cpu_vector is 0 and cpu_irq is low.
- R7: Non-maskable line k (k = 0, 1) drives bit k of the non-maskable status to its level. cpu_nmi is high whenever any status bit is set, including bits set by software.
- R8: A request at an offset above 0x10, or at an offset that is not a multiple of 4, pulses bus_err for exactly one cycle. Such a read returns zero, and such a write changes no register.
- R9: A request of size 0 (byte), 1 (halfword) or 3 reads as zero, changes no register on write and raises no error.
- R10: After reset, every register is zero and cpu_irq, cpu_nmi and cpu_vector are low.
- R11: If a software write to the raw image and a level change on a source line occur in the same cycle, that line's bit takes the line level. Every other bit takes the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | 30 | Level-sensitive source lines; bit n-1 is source n |
| nmi_lines | input | 2 | Non-maskable source lines |
| req_valid | input | 1 | Register access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| req_addr | input | 8 | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid the cycle after a read |
| bus_err | output | 1 | One-cycle pulse after an access to an invalid offset |
| cpu_irq | output | 1 | Maskable interrupt request |
| cpu_vector | output | 8 | Vector for the core |
| cpu_nmi | output | 1 | Non-maskable interrupt request |

## Verification
The hardest case to reach from the ports is a software write to the raw image that lands in the same cycle as a line transition. The line and the write must meet on a single clock edge, and the line-change detector sees only the difference from the previous sample. The bench first parks the lines at a known level. It then sets the new line level and launches the write from the same falling edge, so both take effect on one rising edge. It reads the word back to confirm the merged value and checks that a write with no line change persists.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;

  localparam int WORD_W = 32;
  localparam int VEC_W  = 8;
  localparam logic [VEC_W-1:0] VEC_MULTI = 8'h30;
  localparam logic [VEC_W-1:0] VEC_BASE  = 8'h31;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  typedef enum logic [2:0] {
    SEL_ENABLE,
    SEL_RAW,
    SEL_GATED,
    SEL_NMI,
    SEL_FATAL,
    SEL_NONE
  } reg_sel_e;

  // Offset decode: only word-aligned offsets 0x00..0x10 are valid
  function automatic reg_sel_e decode_off(input logic [7:0] off);
    reg_sel_e s;
    case (off)
      8'h00:   s = SEL_ENABLE;
      8'h04:   s = SEL_RAW;
      8'h08:   s = SEL_GATED;
      8'h0C:   s = SEL_NMI;
      8'h10:   s = SEL_FATAL;
      default: s = SEL_NONE;
    endcase
    return s;
  endfunction

  // Vector from the gated image: none -> 0, several -> shared, one -> base+index
  function automatic logic [VEC_W-1:0] vector_of(input logic [WORD_W-1:0] g);
    logic [VEC_W-1:0] v;
    v = '0;
    if ($countones(g) > 1) begin
      v = VEC_MULTI;
    end else begin
      for (int i = 0; i < WORD_W; i++) begin
        if (g[i]) v = VEC_BASE + VEC_W'(i);
      end
    end
    return v;
  endfunction

endpackage

// File: rtl/irq_hub_edge.sv
module irq_hub_edge #(
  parameter int W = 30
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lines,
  output logic [W-1:0] chg
);
  logic [W-1:0] lines_q;

  always_ff @(posedge clk) begin
    if (!rst_n) lines_q <= '0;
    else        lines_q <= lines;
  end

  assign chg = lines ^ lines_q;
endmodule

// File: rtl/irq_hub_regs.sv
module irq_hub_regs
  import irq_hub_pkg::*;
#(
  parameter int NUM_IRQ = 30,
  parameter int NUM_NMI = 2,
  parameter int ADDR_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [WORD_W-1:0] req_wdata,
  input  logic [NUM_IRQ-1:0] irq_lines,
  input  logic [NUM_IRQ-1:0] irq_chg,
  input  logic [NUM_NMI-1:0] nmi_lines,
  input  logic [NUM_NMI-1:0] nmi_chg,
  input  logic [WORD_W-1:0] gated,
  output logic [WORD_W-1:0] enable_q,
  output logic [WORD_W-1:0] raw_q,
  output logic [WORD_W-1:0] nmi_q,
  output logic [WORD_W-1:0] rd_data,
  output logic              bus_err,
  output logic              addr_bad
);
  reg_sel_e          sel;
  logic              word_acc;
  logic              wr_ok;
  logic [WORD_W-1:0] fatal_q;
  logic [WORD_W-1:0] raw_d;
  logic [WORD_W-1:0] nmi_d;
  logic [WORD_W-1:0] rd_mux;

  assign sel      = decode_off(8'(req_addr));
  assign addr_bad = (sel == SEL_NONE) || (req_addr > ADDR_W'(8'h10));
  assign word_acc = (acc_size_e'(req_size) == SZ_WORD);
  assign wr_ok    = req_valid && req_write && word_acc && !addr_bad;

  always_comb begin
    raw_d = raw_q;
    if (wr_ok && sel == SEL_RAW) raw_d = req_wdata;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (irq_chg[i]) raw_d[i] = irq_lines[i];
    end
  end

  always_comb begin
    nmi_d = nmi_q;
    if (wr_ok && sel == SEL_NMI) nmi_d = req_wdata;
    for (int k = 0; k < NUM_NMI; k++) begin
      if (nmi_chg[k]) nmi_d[k] = nmi_lines[k];
    end
  end

  always_comb begin
    case (sel)
      SEL_ENABLE: rd_mux = enable_q;
      SEL_RAW:    rd_mux = raw_q;
      SEL_GATED:  rd_mux = gated;
      SEL_NMI:    rd_mux = nmi_q;
      SEL_FATAL:  rd_mux = fatal_q;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enable_q <= '0;
      raw_q    <= '0;
      nmi_q    <= '0;
      fatal_q  <= '0;
      rd_data  <= '0;
      bus_err  <= 1'b0;
    end else begin
      raw_q <= raw_d;
      nmi_q <= nmi_d;
      if (wr_ok && sel == SEL_ENABLE) enable_q <= req_wdata;
      if (wr_ok && sel == SEL_FATAL)  fatal_q  <= req_wdata;
      bus_err <= req_valid && addr_bad;
      rd_data <= (req_valid && !req_write && word_acc && !addr_bad) ? rd_mux : '0;
    end
  end
endmodule

// File: rtl/irq_hub_vec.sv
module irq_hub_vec
  import irq_hub_pkg::*;
(
  input  logic [WORD_W-1:0] gated,
  output logic [VEC_W-1:0]  vector,
  output logic              req
);
  assign vector = vector_of(gated);
  assign req    = |gated;
endmodule

// File: rtl/irq_hub.sv
module irq_hub
  import irq_hub_pkg::*;
#(
  parameter int NUM_IRQ = 30,
  parameter int NUM_NMI = 2,
  parameter int ADDR_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_lines,
  input  logic [NUM_NMI-1:0] nmi_lines,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [1:0]         req_size,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [WORD_W-1:0]  req_wdata,
  output logic [WORD_W-1:0]  rd_data,
  output logic               bus_err,
  output logic               cpu_irq,
  output logic [VEC_W-1:0]   cpu_vector,
  output logic               cpu_nmi
);
  logic [NUM_IRQ-1:0] irq_chg;
  logic [NUM_NMI-1:0] nmi_chg;
  logic [WORD_W-1:0]  enable_q;
  logic [WORD_W-1:0]  raw_q;
  logic [WORD_W-1:0]  nmi_q;
  logic [WORD_W-1:0]  gated_w;
  logic               addr_bad_w;

  irq_hub_edge #(.W(NUM_IRQ)) u_irq_edge (
    .clk(clk), .rst_n(rst_n), .lines(irq_lines), .chg(irq_chg)
  );

  irq_hub_edge #(.W(NUM_NMI)) u_nmi_edge (
    .clk(clk), .rst_n(rst_n), .lines(nmi_lines), .chg(nmi_chg)
  );

  irq_hub_regs #(.NUM_IRQ(NUM_IRQ), .NUM_NMI(NUM_NMI), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_size(req_size),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .irq_lines(irq_lines), .irq_chg(irq_chg),
    .nmi_lines(nmi_lines), .nmi_chg(nmi_chg),
    .gated(gated_w),
    .enable_q(enable_q), .raw_q(raw_q), .nmi_q(nmi_q),
    .rd_data(rd_data), .bus_err(bus_err), .addr_bad(addr_bad_w)
  );

  assign gated_w = raw_q & enable_q;

  irq_hub_vec u_vec (
    .gated(gated_w), .vector(cpu_vector), .req(cpu_irq)
  );

  assign cpu_nmi = |nmi_q;
endmodule

// File: rtl/irq_hub_chk.sv
module irq_hub_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        addr_bad,
  input logic        bus_err,
  input logic [31:0] gated,
  input logic [31:0] nmi_q,
  input logic        cpu_irq,
  input logic [7:0]  cpu_vector,
  input logic        cpu_nmi
);
  AST_SINGLE_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(gated) == 1) |-> (cpu_irq && cpu_vector >= 8'h31 && cpu_vector <= 8'h50)); // R4
  AST_MULTI_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(gated) > 1) |-> (cpu_irq && cpu_vector == 8'h30)); // R5
  AST_IDLE_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    (gated == 32'h0) |-> (!cpu_irq && cpu_vector == 8'h00)); // R6
  AST_NMI_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_q != 32'h0) |-> cpu_nmi); // R7
  AST_NMI_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_q == 32'h0) |-> !cpu_nmi); // R7
  AST_BAD_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && addr_bad) |=> bus_err); // R8
  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_err && $past(rst_n)) |-> $past(req_valid && addr_bad)); // R8
endmodule

bind irq_hub irq_hub_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .addr_bad(addr_bad_w),
  .bus_err(bus_err), .gated(gated_w), .nmi_q(nmi_q),
  .cpu_irq(cpu_irq), .cpu_vector(cpu_vector), .cpu_nmi(cpu_nmi)
);

// File: tb/irq_hub_test.sv
`timescale 1ns/1ps
module irq_hub_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [29:0] irq_lines = '0;
  logic [1:0]  nmi_lines = '0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [1:0]  req_size = 2'd2;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rd_data;
  logic        bus_err;
  logic        cpu_irq;
  logic [7:0]  cpu_vector;
  logic        cpu_nmi;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  irq_hub uut (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .nmi_lines(nmi_lines),
    .req_valid(req_valid), .req_write(req_write), .req_size(req_size),
    .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data),
    .bus_err(bus_err), .cpu_irq(cpu_irq), .cpu_vector(cpu_vector), .cpu_nmi(cpu_nmi)
  );

  // {enable mask, lines, expected vector, expected request}
  localparam logic [70:0] TBL [0:7] = '{
    {32'hFFFF_FFFF, 30'h0000_0000, 8'h00, 1'b0},
    {32'hFFFF_FFFF, 30'h0000_0001, 8'h31, 1'b1},
    {32'hFFFF_FFFF, 30'h2000_0000, 8'h4E, 1'b1},
    {32'hFFFF_FFFF, 30'h0000_0005, 8'h30, 1'b1},
    {32'h0000_0004, 30'h0000_0005, 8'h33, 1'b1},
    {32'h0000_0000, 30'h3FFF_FFFF, 8'h00, 1'b0},
    {32'h2000_0000, 30'h3FFF_FFFF, 8'h4E, 1'b1},
    {32'h0000_1000, 30'h0000_1000, 8'h3D, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge
  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d, input logic [1:0] sz = 2'd2);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; req_size = sz;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d, output logic e,
                        input logic [1:0] sz = 2'd2);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_size = sz;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    d = rd_data; e = bus_err;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check("R10 irq", {31'h0, cpu_irq}, 32'h0);
    check("R10 nmi", {31'h0, cpu_nmi}, 32'h0);
    check("R10 vector", {24'h0, cpu_vector}, 32'h0);
    bus_rd(8'h00, d, e); check("R10 enable", d, 32'h0);
    bus_rd(8'h10, d, e); check("R10 fatal", d, 32'h0);

    // R4 R5 R6 R3 table walk
    for (int t = 0; t < 8; t++) begin
      logic [31:0] m;
      m = TBL[t][70:39];
      bus_wr(8'h00, m);
      irq_lines = TBL[t][38:9];
      @(negedge clk);
      check($sformatf("R4/R5/R6 vector entry %0d", t), {24'h0, cpu_vector}, {24'h0, TBL[t][8:1]});
      check($sformatf("R4/R5/R6 irq entry %0d", t), {31'h0, cpu_irq}, {31'h0, TBL[t][0]});
      bus_rd(8'h08, d, e);
      check($sformatf("R3 gated entry %0d", t), d, m & {2'b00, TBL[t][38:9]});
    end

    // R2 line tracking into raw image
    irq_lines = 30'h0000_0102;
    @(negedge clk);
    bus_rd(8'h04, d, e); check("R2 raw set", d, 32'h0000_0102);
    irq_lines = 30'h0000_0100;
    @(negedge clk);
    bus_rd(8'h04, d, e); check("R2 raw clear", d, 32'h0000_0100);

    // R3 writes to gated word have no effect
    bus_wr(8'h00, 32'hFFFF_FFFF);
    bus_wr(8'h08, 32'h0000_0000);
    bus_rd(8'h08, d, e); check("R3 write ignored", d, 32'h0000_0100);

    // R1 readback of writable words
    bus_wr(8'h10, 32'hDEAD_BEEF);
    bus_rd(8'h10, d, e); check("R1 fatal", d, 32'hDEAD_BEEF);
    bus_wr(8'h00, 32'h1234_5678);
    bus_rd(8'h00, d, e); check("R1 enable", d, 32'h1234_5678);

    // R11 same-cycle write and line change; line wins on its bit
    irq_lines = 30'h0;
    @(negedge clk);
    bus_wr(8'h00, 32'hFFFF_FFFF);
    irq_lines = 30'h0000_0008;
    bus_wr(8'h04, 32'hC000_0001);
    bus_rd(8'h04, d, e); check("R11 merged raw", d, 32'hC000_0009);
    check("R11 multi vector", {24'h0, cpu_vector}, 32'h30);
    bus_wr(8'h04, 32'h8000_0000);
    bus_rd(8'h04, d, e); check("R1 raw write persists", d, 32'h8000_0000);
    check("R4 top bit vector", {24'h0, cpu_vector}, 32'h50);
    bus_wr(8'h04, 32'h0);
    check("R6 cleared", {31'h0, cpu_irq}, 32'h0);

    // R7 non-maskable
    nmi_lines = 2'b10;
    @(negedge clk);
    check("R7 nmi high", {31'h0, cpu_nmi}, 32'h1);
    bus_rd(8'h0C, d, e); check("R7 nmi status", d, 32'h2);
    nmi_lines = 2'b00;
    @(negedge clk);
    check("R7 nmi low", {31'h0, cpu_nmi}, 32'h0);
    bus_wr(8'h0C, 32'h0000_0100);
    check("R7 sw nmi", {31'h0, cpu_nmi}, 32'h1);
    bus_wr(8'h0C, 32'h0);
    check("R7 sw nmi clear", {31'h0, cpu_nmi}, 32'h0);

    // R8 invalid offsets
    bus_rd(8'h14, d, e);
    check("R8 err read", {31'h0, e}, 32'h1);
    check("R8 zero read", d, 32'h0);
    @(negedge clk);
    check("R8 one-cycle pulse", {31'h0, bus_err}, 32'h0);
    bus_rd(8'h02, d, e); check("R8 unaligned err", {31'h0, e}, 32'h1);
    bus_wr(8'h18, 32'h0);
    bus_wr(8'h01, 32'h0);
    bus_rd(8'h00, d, e); check("R8 write dropped", d, 32'hFFFF_FFFF);

    // R9 sub-word accesses
    bus_rd(8'h00, d, e, 2'd0);
    check("R9 byte read zero", d, 32'h0);
    check("R9 no error", {31'h0, e}, 32'h0);
    bus_rd(8'h00, d, e, 2'd1); check("R9 half read zero", d, 32'h0);
    bus_wr(8'h00, 32'h0, 2'd1);
    bus_wr(8'h00, 32'h0, 2'd0);
    bus_rd(8'h00, d, e); check("R9 write dropped", d, 32'hFFFF_FFFF);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule